// File: doc/BRIEF.md
# Clock-Domain Rate Change Sequencer

This block carries out a coordinated rate change for one clock domain: a single PLL feeding several integer dividers. A request names the wanted domain rate. The block looks that rate up in a table of up to six variants. Each variant holds a PLL target rate and one divide value for every divider in the domain. The block then decides whether to retune the PLL before or after it writes the dividers.

The order depends on the direction of the PLL move. When the PLL goes down, it is retuned first and the dividers are written afterwards. When it stays the same or goes up, the dividers are loaded first and the PLL is retuned last. In both cases the derived clocks pass through no rate above either their old or their new value. PLL reprogramming is handed to an external engine through a request/done handshake. Divider registers are written through a one-cycle write strobe that carries a register offset and a value.

Top module: `rate_change_seq`

## Requirements
- R1: While reset is asserted and after its release with no request, `pll_req_o`, `div_we_o` and `done_o` stay low and `res_o` reads 0.
- R2: Variants are searched in slot order. A slot whose rate is zero ends the search. The default variants are 200, 400, 600 and 800 with PLL targets 800, 800, 600 and 800, followed by two zero slots. A requested rate that matches no used variant, including a requested rate of zero, ends with `res_o` = 3 (bad rate), with no divider write and no PLL request.
- R3: If the variant's PLL target is below the `pll_cur_i` value sampled with `start_i`, the PLL request is issued before any divider write. The dividers are written only after `pll_done_i`.
- R4: If the PLL target is greater than or equal to the sampled current rate, every divider is written first and the PLL request follows the last write.
- R5: Dividers are written in table order on consecutive cycles, one per cycle, and the list stops at the first zero offset. The default list uses offsets 0x010, 0x014, 0x018 and 0x01C, then offset 0. Their values for the four variants are {4,4,3,4}, {4,2,1,1}, {24,24,18,24} and {16,16,12,16}. The 600 variant therefore gives 3, 1, 18 and 12.
- R6: `pll_req_o` is a single-cycle pulse. `pll_rate_o` carries the variant's PLL target from the request until `pll_done_i`.
- R7: On a valid rate, `res_o` is the `pll_status_i` value sampled with `pll_done_i` (0 ok, 1 timeout, 2 PLL error). When the PLL is lowered, the dividers are still written even if that status is non-zero.
- R8: A `start_i` that arrives while a change is in progress is ignored: it causes no second transaction and no extra `done_o`.
- R9: `done_o` pulses for exactly one cycle at the end of each accepted request, and `res_o` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a rate change (accepted when idle) |
| rate_i | input | 16 | Requested domain rate in MHz |
| pll_cur_i | input | 16 | Present PLL rate in MHz, sampled with start |
| pll_req_o | output | 1 | One-cycle request to the PLL engine |
| pll_rate_o | output | 16 | PLL target rate in MHz for the engine |
| pll_done_i | input | 1 | PLL engine finished |
| pll_status_i | input | 2 | PLL engine status: 0 ok, 1 timeout, 2 error |
| div_we_o | output | 1 | Divider register write strobe |
| div_off_o | output | 12 | Divider register offset |
| div_val_o | output | 8 | Divider value |
| done_o | output | 1 | Sequence finished (one cycle) |
| res_o | output | 2 | Result: 0 ok, 1 timeout, 2 PLL error, 3 bad rate |

## Verification
The hardest case to reach from the ports is the boundary between the two orderings: the PLL target equal to the current rate, which must still follow the dividers-first path. The stimulus sets `pll_cur_i` to exactly the target of a variant. It also changes `pll_cur_i` and pokes `start_i` while a change is running, so the block's capture of the sampled rate and its refusal of a busy start can both be seen. A stub PLL engine answers after a randomized delay with a randomized status. Every run records the position of the PLL request among the divider writes, and that position is compared with the direction the bench derives from its own copy of the table.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_PLL_REQ, S_PLL_WAIT, S_DIVS, S_FIN
  } seq_state_e;

  localparam logic [1:0] RES_OK       = 2'd0;
  localparam logic [1:0] RES_TIMEOUT  = 2'd1;
  localparam logic [1:0] RES_PLL_ERR  = 2'd2;
  localparam logic [1:0] RES_BAD_RATE = 2'd3;
endpackage

// File: rtl/rcs_lookup.sv
module rcs_lookup #(
  parameter int NV = 6,
  parameter int RW = 16,
  parameter int IW = (NV > 1) ? $clog2(NV) : 1,
  parameter logic [RW-1:0] RATE_TBL [NV] = '{default: '0},
  parameter logic [RW-1:0] PLL_TBL  [NV] = '{default: '0}
) (
  input  logic [RW-1:0] rate_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o,
  output logic [RW-1:0] pll_tgt_o
);
  logic stop;

  // first zero slot ends the used part of the table
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    stop  = 1'b0;
    for (int v = 0; v < NV; v++) begin
      if (!stop) begin
        if (RATE_TBL[v] == '0) begin
          stop = 1'b1;
        end else if (RATE_TBL[v] == rate_i) begin
          hit_o = 1'b1;
          idx_o = IW'(v);
          stop  = 1'b1;
        end
      end
    end
  end

  assign pll_tgt_o = PLL_TBL[idx_o];
endmodule

// File: rtl/rcs_div_walker.sv
module rcs_div_walker #(
  parameter int NV = 6,
  parameter int ND = 5,
  parameter int AW = 12,
  parameter int DW = 8,
  parameter int IW = (NV > 1) ? $clog2(NV) : 1,
  parameter int PW = $clog2(ND + 1),
  parameter logic [AW-1:0] OFF_TBL [ND]     = '{default: '0},
  parameter logic [DW-1:0] VAL_TBL [ND][NV] = '{default: '{default: '0}}
) (
  input  logic [IW-1:0] var_i,
  input  logic [PW-1:0] ptr_i,
  output logic [AW-1:0] off_o,
  output logic [DW-1:0] val_o,
  output logic          last_o
);
  logic          in_rng;
  logic [PW-1:0] ps;

  assign in_rng = (int'(ptr_i) < ND);
  assign ps     = in_rng ? ptr_i : '0;
  assign off_o  = in_rng ? OFF_TBL[ps] : '0;
  assign val_o  = VAL_TBL[ps][var_i];
  // zero offset or end of table closes the list
  assign last_o = (off_o == '0);
endmodule

// File: rtl/rate_change_seq.sv
module rate_change_seq
  import rcs_pkg::*;
#(
  parameter int NV = 6,
  parameter int ND = 5,
  parameter int RW = 16,
  parameter int AW = 12,
  parameter int DW = 8,
  parameter logic [RW-1:0] VAR_RATE [NV] = '{16'd200, 16'd400, 16'd600, 16'd800, 16'd0, 16'd0},
  parameter logic [RW-1:0] VAR_PLL  [NV] = '{16'd800, 16'd800, 16'd600, 16'd800, 16'd0, 16'd0},
  parameter logic [AW-1:0] DIV_OFF  [ND] = '{12'h010, 12'h014, 12'h018, 12'h01C, 12'h000},
  parameter logic [DW-1:0] DIV_VAL  [ND][NV] = '{
    '{8'd4,  8'd4,  8'd3,  8'd4,  8'd0, 8'd0},
    '{8'd4,  8'd2,  8'd1,  8'd1,  8'd0, 8'd0},
    '{8'd24, 8'd24, 8'd18, 8'd24, 8'd0, 8'd0},
    '{8'd16, 8'd16, 8'd12, 8'd16, 8'd0, 8'd0},
    '{8'd0,  8'd0,  8'd0,  8'd0,  8'd0, 8'd0}}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [RW-1:0] rate_i,
  input  logic [RW-1:0] pll_cur_i,
  output logic          pll_req_o,
  output logic [RW-1:0] pll_rate_o,
  input  logic          pll_done_i,
  input  logic [1:0]    pll_status_i,
  output logic          div_we_o,
  output logic [AW-1:0] div_off_o,
  output logic [DW-1:0] div_val_o,
  output logic          done_o,
  output logic [1:0]    res_o
);
  localparam int IW = (NV > 1) ? $clog2(NV) : 1;
  localparam int PW = $clog2(ND + 1);

  seq_state_e    state_q;
  logic [RW-1:0] rate_q, cur_q, tgt_q, lk_tgt;
  logic [IW-1:0] idx_q, lk_idx;
  logic [PW-1:0] ptr_q;
  logic          lower_q, lk_hit, lk_lower, wk_last;
  logic [1:0]    res_q;

  rcs_lookup #(
    .NV(NV), .RW(RW), .IW(IW), .RATE_TBL(VAR_RATE), .PLL_TBL(VAR_PLL)
  ) u_lookup (
    .rate_i(rate_q), .hit_o(lk_hit), .idx_o(lk_idx), .pll_tgt_o(lk_tgt)
  );

  rcs_div_walker #(
    .NV(NV), .ND(ND), .AW(AW), .DW(DW), .IW(IW), .PW(PW),
    .OFF_TBL(DIV_OFF), .VAL_TBL(DIV_VAL)
  ) u_walker (
    .var_i(idx_q), .ptr_i(ptr_q), .off_o(div_off_o), .val_o(div_val_o),
    .last_o(wk_last)
  );

  assign lk_lower = (lk_tgt < cur_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      rate_q  <= '0;
      cur_q   <= '0;
      tgt_q   <= '0;
      idx_q   <= '0;
      ptr_q   <= '0;
      lower_q <= 1'b0;
      res_q   <= RES_OK;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          rate_q  <= rate_i;
          cur_q   <= pll_cur_i;
          state_q <= S_CHECK;
        end
        S_CHECK: begin
          if (!lk_hit) begin
            res_q   <= RES_BAD_RATE;
            state_q <= S_FIN;
          end else begin
            idx_q   <= lk_idx;
            tgt_q   <= lk_tgt;
            lower_q <= lk_lower;
            ptr_q   <= '0;
            res_q   <= RES_OK;
            state_q <= lk_lower ? S_PLL_REQ : S_DIVS;
          end
        end
        S_PLL_REQ: state_q <= S_PLL_WAIT;
        S_PLL_WAIT: if (pll_done_i) begin
          res_q   <= pll_status_i;
          state_q <= lower_q ? S_DIVS : S_FIN;
        end
        S_DIVS: begin
          if (wk_last) state_q <= lower_q ? S_FIN : S_PLL_REQ;
          else         ptr_q   <= ptr_q + 1'b1;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign pll_req_o  = (state_q == S_PLL_REQ);
  assign pll_rate_o = tgt_q;
  assign div_we_o   = (state_q == S_DIVS) && !wk_last;
  assign done_o     = (state_q == S_FIN);
  assign res_o      = res_q;

  p_bad_rate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHECK && !lk_hit) |=> (done_o && res_o == RES_BAD_RATE));
  p_lower_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHECK && lk_hit && lk_lower) |=> pll_req_o);
  p_raise_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHECK && lk_hit && !lk_lower) |=> !pll_req_o);
  p_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(div_we_o && pll_req_o));
  p_off_nz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_we_o |-> (div_off_o != '0));
  p_req_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_req_o |=> !pll_req_o);
  p_rate_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PLL_WAIT) |-> $stable(pll_rate_o));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/tb_rate_change_seq.sv
module tb_rate_change_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, pll_done_i = 1'b0;
  logic [15:0] rate_i = '0, pll_cur_i = '0;
  logic [1:0]  pll_status_i = '0;
  logic        pll_req_o, div_we_o, done_o;
  logic [15:0] pll_rate_o;
  logic [11:0] div_off_o;
  logic [7:0]  div_val_o;
  logic [1:0]  res_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rate_change_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .rate_i(rate_i),
    .pll_cur_i(pll_cur_i), .pll_req_o(pll_req_o), .pll_rate_o(pll_rate_o),
    .pll_done_i(pll_done_i), .pll_status_i(pll_status_i), .div_we_o(div_we_o),
    .div_off_o(div_off_o), .div_val_o(div_val_o), .done_o(done_o), .res_o(res_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int var_rate(input int v);
    case (v) 0: return 200; 1: return 400; 2: return 600; 3: return 800; default: return 0; endcase
  endfunction
  function automatic int var_pll(input int v);
    case (v) 2: return 600; default: return 800; endcase
  endfunction
  function automatic int div_off(input int d);
    return 16 + 4 * d;
  endfunction
  function automatic int div_val(input int d, input int v);
    case (d)
      0: return (v == 2) ? 3 : 4;
      1: case (v) 0: return 4; 1: return 2; default: return 1; endcase
      2: return (v == 2) ? 18 : 24;
      default: return (v == 2) ? 12 : 16;
    endcase
  endfunction
  function automatic int find_var(input int r);
    for (int v = 0; v < 4; v++) if (r != 0 && var_rate(v) == r) return v;
    return -1;
  endfunction

  task automatic run(input int rate, input int cur, input int st,
                     input bit poke, input int dly);
    int w_off[8], w_val[8];
    int nw = 0, nreq = 0, req_pos = -1, lastc = -10, cyc = 0, cnt = 0;
    int prate = 0, res = 0, v;
    bit seen = 0, consec = 1;
    @(negedge clk);
    rate_i = 16'(rate); pll_cur_i = 16'(cur); start_i = 1'b1;
    while (!seen && cyc < 200) begin
      @(negedge clk);
      cyc++;
      start_i = poke && cyc <= 3;
      if (poke) rate_i = 16'd200;
      pll_cur_i = 16'd2000;  // later changes must not matter
      pll_done_i = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin pll_done_i = 1'b1; pll_status_i = 2'(st); end
      end
      if (pll_req_o) begin nreq++; req_pos = nw; prate = pll_rate_o; cnt = dly; end
      if (div_we_o) begin
        if (nw > 0 && cyc != lastc + 1) consec = 0;
        if (nw < 8) begin w_off[nw] = div_off_o; w_val[nw] = div_val_o; end
        nw++; lastc = cyc;
      end
      if (done_o) begin seen = 1; res = res_o; end
    end
    start_i = 1'b0; pll_done_i = 1'b0;
    chk(seen, "R9", "done seen", seen, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!done_o, "R9", "done single pulse / no stray done (R8)", done_o, 0);
      chk(!div_we_o && !pll_req_o, "R8", "no activity after done", div_we_o | pll_req_o, 0);
    end
    v = find_var(rate);
    if (v < 0) begin
      chk(nw == 0, "R2", "writes on bad rate", nw, 0);
      chk(nreq == 0, "R2", "pll reqs on bad rate", nreq, 0);
      chk(res == 3, "R2", "result bad rate", res, 3);
    end else begin
      chk(nreq == 1, "R6", "pll request count", nreq, 1);
      chk(prate == var_pll(v), "R6", "pll target", prate, var_pll(v));
      if (var_pll(v) < cur)
        chk(req_pos == 0, "R3", "lowering: pll before dividers", req_pos, 0);
      else
        chk(req_pos == 4, "R4", "raise/equal: pll after dividers", req_pos, 4);
      chk(nw == 4, "R5", "divider write count", nw, 4);
      for (int d = 0; d < 4 && d < nw; d++) begin
        chk(w_off[d] == div_off(d), "R5", "divider offset", w_off[d], div_off(d));
        chk(w_val[d] == div_val(d, v), "R5", "divider value", w_val[d], div_val(d, v));
      end
      chk(consec, "R5", "writes on consecutive cycles", consec, 1);
      chk(res == st, "R7", "result is pll status", res, st);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) begin
      @(negedge clk);
      chk(!pll_req_o && !div_we_o && !done_o && res_o == 0, "R1", "outputs in reset",
          {pll_req_o, div_we_o, done_o}, 0);
    end
    rst_ni = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!pll_req_o && !div_we_o && !done_o && res_o == 0, "R1", "idle after reset",
          {pll_req_o, div_we_o, done_o}, 0);
    end
    run(600, 800, 0, 0, 2);  // R3 lowering, example variant
    run(600, 600, 0, 0, 1);  // R4 equal boundary
    run(800, 600, 0, 0, 3);  // R4 raise
    run(0, 800, 0, 0, 1);    // R2 zero rate
    run(1000, 800, 0, 0, 1); // R2 unknown rate
    run(400, 900, 1, 0, 2);  // R7 lowering with timeout still writes
    run(200, 700, 2, 1, 4);  // R8 busy start, R7 error status
    for (int i = 0; i < 40; i++) begin
      int pick, r, c;
      pick = $urandom_range(0, 5);
      if (pick < 4) r = var_rate(pick);
      else if (pick == 4) r = $urandom_range(1, 1200);
      else r = 0;
      case ($urandom_range(0, 3))
        0: c = 500; 1: c = 600; 2: c = 800; default: c = $urandom_range(100, 1600);
      endcase
      run(r, c, $urandom_range(0, 2), $urandom_range(0, 1) == 1 && pick < 4,
          $urandom_range(1, 4));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule